// File: doc/BRIEF.md
# Serial Audio Link Output Frame Builder

This block produces the outgoing half of an AC'97-style serial audio link. It runs in the bit-clock domain and repeats a 256-bit frame. Each frame opens with a 16-bit tag slot and continues with twelve 20-bit data slots. The block drives a frame sync and a single serial data line. Every output changes on a rising bit-clock edge, so the codec can sample on the falling edge that follows.

Upstream logic supplies the following inputs:
- twelve 20-bit slot words, each holding its sample left-justified;
- a valid flag for each slot;
- a sample-width code;
- a codec ID.

At each frame boundary the block copies all of these into a shadow buffer and raises a one-cycle frame-start strobe. Upstream logic may then prepare the next frame at any time before the following strobe. The block builds the tag from the latched flags. It sends every slot MSB first, and it sends zero in any position that carries no data.

Top module: `aclink_tx_framer`

## Requirements
- R1: While `rstN` is low, `syncOut`, `sdataOut` and `frameStart` are all 0.
- R2: After reset the output is a repeating 256-cycle frame. `syncOut` is high for 16 consecutive cycles and low for the remaining 240. It first rises on the first rising edge after reset is released.
- R3: `frameStart` is a one-cycle pulse that rises on the same edge as `syncOut`. On that edge the slot words, valid flags, width code and codec ID are captured for the frame that follows.
- R4: On the edge after `syncOut` rises, `sdataOut` carries tag bit 15 (frame valid). One new bit follows on each later edge.
- R5: The tag is sent MSB first and has this layout:
  - bit 15 is 1 when any slot valid flag is set;
  - bit 15−k is the flag of slot k, for k = 1..12;
  - bit 2 is always 0;
  - bits 1:0 are the codec ID.
- R6: After the tag come slots 1 to 12 in order, 20 bits each, each sent MSB first. Slot k occupies frame positions 16+20(k−1) to 35+20(k−1). Slot k's word is `slotData[20k−1:20k−20]`.
- R7: The width code selects the sample length: 0 means 16 bits, 1 means 18 bits, 2 or 3 means 20 bits. Bit positions of a valid slot past that length are sent as 0.
- R8: Every bit of a slot whose valid flag is 0 is sent as 0, whatever its word holds. Slot k's flag is `slotValid[k−1]`.
- R9: Input changes between two `frameStart` pulses have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| slotData | input | 240 | Twelve left-justified 20-bit slot words, slot 1 in the low bits |
| slotValid | input | 12 | Valid flag per slot, slot 1 in bit 0 |
| sampleWidth | input | 2 | Sample length code (0: 16, 1: 18, else 20 bits) |
| codecId | input | 2 | Codec ID placed in the two tag LSBs |
| frameStart | output | 1 | One-cycle pulse when the inputs are captured |
| syncOut | output | 1 | Frame sync |
| sdataOut | output | 1 | Serial frame data |

## Verification
The hardest case to reach from the ports is an input change that lands in the middle of a frame, because a correct design hides it completely. After every frame-start pulse the bench drives deliberately mismatched data and flags. Roughly 120 cycles later it drives the intended pattern for the next frame. A reference model records only what was present at each capture edge, so any leak from the shadow buffer shows up as a bit mismatch. The patterns also cover every width code, including the rarely used code 3, an all-invalid frame and a full-valid frame.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int NUM_SLOTS  = 12;
  localparam int SLOT_BITS  = 20;
  localparam int ID_BITS    = 2;
  localparam int TAG_BITS   = 1 + NUM_SLOTS + 1 + ID_BITS;
  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
  localparam int BIT_IDX_W  = $clog2(SLOT_BITS);

  typedef struct packed {
    logic                  loadShadow;
    logic                  inTag;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic [BIT_IDX_W-1:0]  bitIdx;
  } ctlStrobeT;
endpackage

// File: rtl/aclink_tx_ctl.sv
module aclink_tx_ctl
  import aclink_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output ctlStrobeT strobes,
  output logic      frameStart,
  output logic      syncOut
);
  logic [CNT_W-1:0]      frameCnt;
  logic [SLOT_IDX_W-1:0] slotCnt;
  logic [BIT_IDX_W-1:0]  bitCnt;
  logic                  lastPos;
  logic                  tagLast;
  logic                  slotLast;

  assign lastPos  = (slotCnt == SLOT_IDX_W'(NUM_SLOTS)) && (bitCnt == BIT_IDX_W'(SLOT_BITS - 1));
  assign tagLast  = (slotCnt == '0) && (bitCnt == BIT_IDX_W'(TAG_BITS - 1));
  assign slotLast = (bitCnt == BIT_IDX_W'(SLOT_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt   <= '1;
      slotCnt    <= SLOT_IDX_W'(NUM_SLOTS);
      bitCnt     <= BIT_IDX_W'(SLOT_BITS - 1);
      syncOut    <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameCnt   <= frameCnt + 1'b1;
      frameStart <= lastPos;
      syncOut    <= lastPos || ((slotCnt == '0) && (bitCnt < BIT_IDX_W'(TAG_BITS - 1)));
      if (lastPos) begin
        slotCnt <= '0;
        bitCnt  <= '0;
      end else if (tagLast || slotLast) begin
        slotCnt <= slotCnt + 1'b1;
        bitCnt  <= '0;
      end else begin
        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadShadow = lastPos;
    strobes.inTag      = (slotCnt == '0);
    strobes.slotIdx    = slotCnt;
    strobes.bitIdx     = bitCnt;
  end

  AST_SYNC_WITH_FS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> frameStart); // R3
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart); // R3
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt == '1) |-> lastPos); // R2
endmodule

// File: rtl/aclink_tx_dp.sv
module aclink_tx_dp
  import aclink_tx_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobeT                      strobes,
  input  logic [NUM_SLOTS*SLOT_BITS-1:0] slotData,
  input  logic [NUM_SLOTS-1:0]           slotValid,
  input  logic [1:0]                     sampleWidth,
  input  logic [ID_BITS-1:0]             codecId,
  output logic                           sdataOut
);
  logic [SLOT_BITS-1:0] wordIn [NUM_SLOTS];
  logic [SLOT_BITS-1:0] wordSh [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] validSh;
  logic [1:0]           widthSh;
  logic [ID_BITS-1:0]   idSh;
  logic [TAG_BITS-1:0]  tagWord;
  logic [BIT_IDX_W-1:0] widthBits;
  logic [SLOT_IDX_W-1:0] slotSel;
  logic [BIT_IDX_W-1:0] dataSel;
  logic [BIT_IDX_W-1:0] tagSel;
  logic                 nextBit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_unpack
    assign wordIn[s] = slotData[s*SLOT_BITS +: SLOT_BITS];
    assign tagWord[TAG_BITS-2-s] = validSh[s];
  end
  assign tagWord[TAG_BITS-1]      = |validSh;
  assign tagWord[ID_BITS]         = 1'b0;
  assign tagWord[ID_BITS-1:0]     = idSh;

  always_comb begin
    case (widthSh)
      2'd0:    widthBits = BIT_IDX_W'(16);
      2'd1:    widthBits = BIT_IDX_W'(18);
      default: widthBits = BIT_IDX_W'(SLOT_BITS);
    endcase
  end

  assign slotSel = strobes.slotIdx - 1'b1;
  assign dataSel = BIT_IDX_W'(SLOT_BITS - 1) - strobes.bitIdx;
  assign tagSel  = BIT_IDX_W'(TAG_BITS - 1) - strobes.bitIdx;

  always_comb begin
    if (strobes.inTag)
      nextBit = tagWord[tagSel[$clog2(TAG_BITS)-1:0]];
    else
      nextBit = validSh[slotSel] && (strobes.bitIdx < widthBits) && wordSh[slotSel][dataSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) wordSh[s] <= '0;
      validSh  <= '0;
      widthSh  <= '0;
      idSh     <= '0;
      sdataOut <= 1'b0;
    end else begin
      sdataOut <= nextBit;
      if (strobes.loadShadow) begin
        for (int s = 0; s < NUM_SLOTS; s++) wordSh[s] <= wordIn[s];
        validSh <= slotValid;
        widthSh <= sampleWidth;
        idSh    <= codecId;
      end
    end
  end

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.inTag && !validSh[slotSel]) |=> !sdataOut); // R8
  AST_TRAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.inTag && (strobes.bitIdx >= widthBits)) |=> !sdataOut); // R7
  AST_TAG_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inTag && (strobes.bitIdx == BIT_IDX_W'(TAG_BITS - 1 - ID_BITS))) |=> !sdataOut); // R5
  AST_FRAME_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inTag && (strobes.bitIdx == '0)) |=> (sdataOut == $past(|validSh))); // R5
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SLOTS*SLOT_BITS-1:0] slotData,
  input  logic [NUM_SLOTS-1:0]           slotValid,
  input  logic [1:0]                     sampleWidth,
  input  logic [ID_BITS-1:0]             codecId,
  output logic                           frameStart,
  output logic                           syncOut,
  output logic                           sdataOut
);
  ctlStrobeT strobes;

  aclink_tx_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .frameStart (frameStart),
    .syncOut    (syncOut)
  );

  aclink_tx_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .slotData    (slotData),
    .slotValid   (slotValid),
    .sampleWidth (sampleWidth),
    .codecId     (codecId),
    .sdataOut    (sdataOut)
  );
endmodule

// File: tb/tb_aclink_tx_framer.sv
module tb_aclink_tx_framer;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [239:0] slotData = '0;
  logic [11:0]  slotValid = '0;
  logic [1:0]   sampleWidth = '0;
  logic [1:0]   codecId = '0;
  logic         frameStart, syncOut, sdataOut;

  aclink_tx_framer dut (
    .clk(clk), .rstN(rstN), .slotData(slotData), .slotValid(slotValid),
    .sampleWidth(sampleWidth), .codecId(codecId),
    .frameStart(frameStart), .syncOut(syncOut), .sdataOut(sdataOut)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int           pos = 255;
  logic [239:0] refData = '0;
  logic [11:0]  refValid = '0;
  logic [1:0]   refWidth = '0;
  logic [1:0]   refId = '0;
  logic         expSync = 0, expData = 0, expFs = 0;
  string        dataReq = "R1";

  function automatic logic modelBit(input int p, output string req);
    logic [15:0] tag;
    int s, b, w;
    if (p < 16) begin
      tag = '0;
      tag[15] = |refValid;
      for (int k = 1; k <= 12; k++) tag[15-k] = refValid[k-1];
      tag[1:0] = refId;
      req = (p == 0) ? "R4" : "R5";
      return tag[15-p];
    end
    s = (p - 16) / 20;
    b = (p - 16) % 20;
    w = (refWidth == 2'd0) ? 16 : (refWidth == 2'd1) ? 18 : 20;
    if (!refValid[s]) begin req = "R8 R9"; return 1'b0; end
    if (b >= w) begin req = "R7 R9"; return 1'b0; end
    req = "R6 R9";
    return refData[s*20 + 19 - b];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pos = 255; expSync = 0; expData = 0; expFs = 0; dataReq = "R1";
    end else begin
      expSync = (pos == 255) || (pos < 15);
      expFs   = (pos == 255);
      expData = modelBit(pos, dataReq);
      if (pos == 255) begin
        refData = slotData; refValid = slotValid;
        refWidth = sampleWidth; refId = codecId;
      end
      pos = (pos + 1) % 256;
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check(syncOut,    expSync, rstN ? "R2" : "R1", "syncOut");
      check(frameStart, expFs,   rstN ? "R3" : "R1", "frameStart");
      check(sdataOut,   expData, dataReq,            "sdataOut");
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic randData();
    for (int i = 0; i < 8; i++) slotData[i*32 +: 32] = $urandom;
  endtask

  task automatic applyPattern(input int n);
    randData();
    case (n)
      1: begin slotValid = 12'hA5A; sampleWidth = 2'd0; codecId = 2'd1; end
      2: begin slotValid = 12'h3C3; sampleWidth = 2'd1; codecId = 2'd2; end
      3: begin slotValid = 12'hFFF; sampleWidth = 2'd3; codecId = 2'd3; end
      4: begin slotValid = 12'h000; sampleWidth = 2'd2; codecId = 2'd2; end
      5: begin slotValid = 12'hFFF; sampleWidth = 2'd0; codecId = 2'd3; end
      default: begin slotValid = 12'h801; sampleWidth = 2'd2; codecId = 2'd0; end
    endcase
  endtask

  initial begin
    // first frame: all slots valid, 20-bit samples (R6)
    randData();
    slotValid = 12'hFFF; sampleWidth = 2'd2; codecId = 2'd1;
    repeat (4) @(negedge clk);   // R1 checked during these cycles
    rstN = 1'b1;
    for (int n = 1; n <= 7; n++) begin
      do @(negedge clk); while (!frameStart);
      // R9: junk applied mid-frame must not reach the current frame
      randData();
      slotValid = ~slotValid;
      sampleWidth = sampleWidth + 2'd1;
      codecId = ~codecId;
      repeat (120) @(negedge clk);
      applyPattern(n);
    end
    do @(negedge clk); while (!frameStart);
    repeat (260) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule